// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of an Ethernet PHY over the two-wire management interface. Software loads a small register set: a combined PHY/register address, an optional 16-bit write value and an MDC divider. It then sets a start bit. The block drives MDC from the system clock and shifts a complete 64-bit management frame onto MDIO. On a read it lets go of the line for the turnaround and collects the PHY's 16 data bits. A status bit stays high for the whole frame. When it drops, a read result is waiting in the read-data register.

The host side is reduced to a register index with a write strobe and a read strobe. The MDIO pad is modelled as three separate signals: output, output enable and input. The pad itself and the PHY are outside the block.

Top module: `mdio_station`

Register indices on `regAddr`:
- 0: configuration. The divider is in bits 5:2.
- 1: address. The PHY address is in bits 12:8 and the register number in bits 4:0.
- 2: write data, bits 15:0.
- 3: command. Bit 0 is the start bit.
- 4: status. Bit 0 is busy.
- 5: read data, bits 15:0.

Bits that a register does not define read as 0. A read of any index returns 0 while `regRdEn` is low.

## Requirements
- R1: After reset the following hold: busy reads 0, MDC is low, the MDIO output enable is low, the address, write-data and read-data registers read 0, and the divider field reads 0xD.
- R2: Readback of an index shows only its defined fields. After writing all ones, the address register reads 0x1F1F, the configuration register reads 0x3C and the write-data register reads 0xFFFF.
- R3: A write to the command index with bit 0 set while idle starts a transaction. The status bit 0 then reads 1 for exactly 128*(D+1) clock cycles, where D is the divider value in force at the start, and then reads 0.
- R4: MDC is low when idle. During a transaction it makes 64 periods, with high and low phases of D+1 clock cycles each.
- R5: Every frame starts with 32 ones, then 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address and the 5-bit register number. Fields go out most significant bit first. MDIO changes only while MDC is low.
- R6: A write frame continues with a driven turnaround of 10 and the 16 bits of the write-data register, MSB first. The output enable is high for the whole frame.
- R7: A read frame releases MDIO (output enable low) from frame bit 46 to the end. It samples 16 bits on rising MDC edges, MSB first, and the result sits in the read-data register when busy falls. The read-data register changes only at that moment.
- R8: A transaction is a write only if the write-data register was written since the previous start. Otherwise it is a read.
- R9: A start request while busy is ignored. This includes a request in the very cycle the running frame ends. The running frame is unaltered and no further frame follows.
- R10: A command write with bit 0 clear starts nothing.
- R11: A write transaction leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Register read value (combinational) |
| mdcOut | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value to drive |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the pad |

## Verification
Two functions can fall in the same cycle: a new start request and the completion of the running frame, when busy drops. The bench places a command write exactly on the edge where the last falling MDC edge clears busy. It also places one in the middle of a frame. In both cases it requires the following:
- the busy window keeps its exact length;
- the captured frame is unchanged;
- status reads 0 and MDC stays low in the cycles after the end.

Random frames mix reads and writes, addresses, data and small dividers. They are judged by a PHY model that captures every bit on rising MDC edges and compares the capture with a frame computed in the bench.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef logic [2:0] regIdx_t;

  localparam regIdx_t IDX_CFG   = 3'd0;
  localparam regIdx_t IDX_ADDR  = 3'd1;
  localparam regIdx_t IDX_WDATA = 3'd2;
  localparam regIdx_t IDX_CMD   = 3'd3;
  localparam regIdx_t IDX_STAT  = 3'd4;
  localparam regIdx_t IDX_RDATA = 3'd5;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // capture a new frame and latch the transaction type
    logic shift;   // advance to the next frame bit (falling MDC)
    logic sample;  // take one read bit from the line (rising MDC)
    logic lineOff; // stop driving MDIO (read turnaround)
    logic finish;  // last bit done
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 4,
  parameter int FRAME_BITS = 64,
  parameter int TA_POS     = 46,
  parameter int DATA_POS   = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             opWrite,
  input  logic [DIV_W-1:0] divVal,
  output logic             busy,
  output logic             mdcOut,
  output mdioStrobe_t      strobes
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] PRE_TA   = CNT_W'(TA_POS - 1);
  localparam logic [CNT_W-1:0] FIRST_RD = CNT_W'(DATA_POS);

  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] divHold;
  logic [CNT_W-1:0] bitIdx;
  logic             mdcLvl;
  logic             busyQ;

  logic launch;
  logic phaseEnd;
  logic fallNow;
  logic riseNow;
  logic lastBit;

  assign launch   = startReq && !busyQ;
  assign phaseEnd = busyQ && (halfCnt == divHold);
  assign fallNow  = phaseEnd && mdcLvl;
  assign riseNow  = phaseEnd && !mdcLvl;
  assign lastBit  = (bitIdx == LAST_IDX);

  always_comb begin
    strobes         = '0;
    strobes.load    = launch;
    strobes.shift   = fallNow && !lastBit;
    strobes.finish  = fallNow && lastBit;
    strobes.sample  = riseNow && !opWrite && (bitIdx >= FIRST_RD);
    strobes.lineOff = fallNow && !opWrite && (bitIdx == PRE_TA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      mdcLvl  <= 1'b0;
      halfCnt <= '0;
      divHold <= '0;
      bitIdx  <= '0;
    end else if (launch) begin
      busyQ   <= 1'b1;
      mdcLvl  <= 1'b0;
      halfCnt <= '0;
      divHold <= divVal;
      bitIdx  <= '0;
    end else if (busyQ) begin
      if (phaseEnd) begin
        halfCnt <= '0;
        mdcLvl  <= ~mdcLvl;
        if (mdcLvl) begin
          if (lastBit) begin
            busyQ <= 1'b0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign busy   = busyQ;
  assign mdcOut = mdcLvl;

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int DIV_W     = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_BITS  = 32,
  parameter logic [DIV_W-1:0] DIV_RESET = 4'hD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  regIdx_t           regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  mdioStrobe_t       strobes,
  input  logic              busy,
  output logic              startReq,
  output logic              opWrite,
  output logic [DIV_W-1:0]  divVal,
  output logic [DATA_W-1:0] readDataQ,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int FRAME_BITS = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int PHY_LSB    = 8;
  localparam int DIV_LSB    = 2;

  logic [DIV_W-1:0]      cfgDiv;
  logic [ADDR_W-1:0]     phyAddr;
  logic [ADDR_W-1:0]     regNum;
  logic [DATA_W-1:0]     wrData;
  logic [DATA_W-1:0]     rdData;
  logic [DATA_W-1:0]     rdShift;
  logic [FRAME_BITS-1:0] frameSh;
  logic [FRAME_BITS-1:0] frameNext;
  logic                  wrPending;
  logic                  opLatched;
  logic                  oeQ;

  logic wrCfg, wrAddr, wrWdata, wrCmd;
  logic unusedWrBits;

  assign wrCfg   = regWrEn && (regAddr == IDX_CFG);
  assign wrAddr  = regWrEn && (regAddr == IDX_ADDR);
  assign wrWdata = regWrEn && (regAddr == IDX_WDATA);
  assign wrCmd   = regWrEn && (regAddr == IDX_CMD);

  assign startReq     = wrCmd && regWrData[0];
  assign unusedWrBits = ^regWrData[BUS_W-1:DATA_W];

  // Host-visible registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDiv  <= DIV_RESET;
      phyAddr <= '0;
      regNum  <= '0;
      wrData  <= '0;
    end else begin
      if (wrCfg)   cfgDiv  <= regWrData[DIV_LSB +: DIV_W];
      if (wrAddr)  begin
        phyAddr <= regWrData[PHY_LSB +: ADDR_W];
        regNum  <= regWrData[0 +: ADDR_W];
      end
      if (wrWdata) wrData  <= regWrData[DATA_W-1:0];
    end
  end

  // Transaction type: write only if write data arrived since the last start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPending <= 1'b0;
      opLatched <= 1'b0;
    end else if (strobes.load) begin
      wrPending <= 1'b0;
      opLatched <= wrPending;
    end else if (wrWdata) begin
      wrPending <= 1'b1;
    end
  end

  always_comb begin
    frameNext = {{PRE_BITS{1'b1}}, 2'b01,
                 (wrPending ? 2'b01 : 2'b10),
                 phyAddr, regNum, 2'b10,
                 (wrPending ? wrData : {DATA_W{1'b1}})};
  end

  // Outgoing shift register and pad enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSh <= {FRAME_BITS{1'b1}};
      oeQ     <= 1'b0;
    end else begin
      if (strobes.load) begin
        frameSh <= frameNext;
        oeQ     <= 1'b1;
      end else begin
        if (strobes.shift) frameSh <= {frameSh[FRAME_BITS-2:0], 1'b1};
        if (strobes.lineOff || strobes.finish) oeQ <= 1'b0;
      end
    end
  end

  // Incoming read bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0;
      rdData  <= '0;
    end else begin
      if (strobes.sample) rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (strobes.finish && !opLatched) rdData <= rdShift;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        IDX_CFG:   regRdData[DIV_LSB +: DIV_W] = cfgDiv;
        IDX_ADDR:  begin
          regRdData[PHY_LSB +: ADDR_W] = phyAddr;
          regRdData[0 +: ADDR_W]       = regNum;
        end
        IDX_WDATA: regRdData[DATA_W-1:0] = wrData;
        IDX_STAT:  regRdData[0] = busy;
        IDX_RDATA: regRdData[DATA_W-1:0] = rdData;
        default:   regRdData = '0;
      endcase
    end
  end

  assign opWrite   = opLatched;
  assign divVal    = cfgDiv;
  assign readDataQ = rdData;
  assign mdioOut   = frameSh[FRAME_BITS-1];
  assign mdioOe    = oeQ;

endmodule

// File: rtl/mdio_station.sv
module mdio_station
  import mdio_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int DIV_W    = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [BUS_W-1:0] regWrData,
  output logic [BUS_W-1:0] regRdData,
  output logic             mdcOut,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);

  localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int FRAME_BITS = DATA_POS + DATA_W;

  mdioStrobe_t      strobes;
  logic             busyW;
  logic             startReqW;
  logic             opWriteW;
  logic [DIV_W-1:0] divW;
  logic [DATA_W-1:0] rdDataW;

  mdio_ctrl #(
    .DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS),
    .TA_POS(TA_POS), .DATA_POS(DATA_POS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReqW), .opWrite(opWriteW), .divVal(divW),
    .busy(busyW), .mdcOut(mdcOut), .strobes(strobes)
  );

  mdio_datapath #(
    .BUS_W(BUS_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .PRE_BITS(PRE_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .strobes(strobes), .busy(busyW),
    .startReq(startReqW), .opWrite(opWriteW), .divVal(divW),
    .readDataQ(rdDataW),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

endmodule

// File: rtl/mdio_station_chk.sv
module mdio_station_chk #(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [BUS_W-1:0]  regWrData,
  input logic              busy,
  input logic              opWrite,
  input logic              mdcOut,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic [DATA_W-1:0] rdData
);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd3 && regWrData[0] && !busy) |=> busy);

  p_mdc_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdcOut);

  p_line_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    mdcOut |-> $stable(mdioOut));

  p_drive_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opWrite) |-> mdioOe);

  p_oe_only_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> ($fell(busy) && !$past(opWrite)));

endmodule

bind mdio_station mdio_station_chk #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .busy(busyW), .opWrite(opWriteW),
  .mdcOut(mdcOut), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdDataW)
);

// File: tb/tb_mdio_station.sv
module tb_mdio_station;

  localparam logic [2:0] CFG = 3'd0, ADR = 3'd1, WDT = 3'd2,
                         CMD = 3'd3, STA = 3'd4, RDT = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdcOut, mdioOut, mdioOe, mdioIn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_station dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .mdcOut(mdcOut), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model
  logic        phyOe = 1'b0;
  logic        phyBit = 1'b1;
  logic [15:0] phyData = '0;
  logic [63:0] captured = '0;
  int          phyCnt = 0;
  bit          expectRead = 0;
  bit          conflict = 0;

  assign mdioIn = mdioOe ? mdioOut : (phyOe ? phyBit : 1'b1);

  always @(posedge mdcOut) begin
    if (expectRead && phyCnt >= 46 && mdioOe) conflict = 1;
    captured = {captured[62:0], mdioIn};
    phyCnt   = phyCnt + 1;
  end

  always @(negedge mdcOut) begin
    if (expectRead && phyCnt == 47) begin
      phyOe = 1'b1; phyBit = 1'b0;
    end else if (expectRead && phyCnt >= 48 && phyCnt <= 63) begin
      phyOe = 1'b1; phyBit = phyData[63 - phyCnt];
    end else begin
      phyOe = 1'b0; phyBit = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input bit wr, input logic [4:0] phy,
                                           input logic [4:0] rn, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rn, 2'b10, d};
  endfunction

  task automatic wrReg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    regAddr = idx; regWrData = val; regWrEn = 1'b1; regRdEn = 1'b0;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    regAddr = idx; regRdEn = 1'b1;
    #1 val = regRdData;
    regRdEn = 1'b0;
  endtask

  // One transaction; midStart >= 0 injects a start request at that busy sample.
  task automatic runTxn(input bit doWr, input logic [4:0] phy, input logic [4:0] rn,
                        input logic [15:0] dat, input logic [3:0] div, input int midStart);
    logic [31:0] prevRd, got;
    int busyCnt, hi, rises, guard, nExp;
    bit prev, injected;
    wrReg(CFG, 32'(div) << 2);
    wrReg(ADR, (32'(phy) << 8) | 32'(rn));
    if (doWr) wrReg(WDT, 32'(dat));
    rdReg(RDT, prevRd);
    phyData = dat; expectRead = !doWr; phyCnt = 0; phyOe = 0; conflict = 0; captured = '0;
    wrReg(CMD, 32'd1);
    regAddr = STA; regRdEn = 1'b1;
    #1;
    busyCnt = 0; hi = 0; rises = 0; guard = 0; prev = 0; injected = 0;
    while (regRdData[0] && guard < 5000) begin
      busyCnt++;
      if (mdcOut) hi++;
      if (mdcOut && !prev) rises++;
      prev = mdcOut;
      if (busyCnt == midStart) begin
        regAddr = CMD; regWrData = 32'd1; regWrEn = 1'b1; regRdEn = 1'b0; injected = 1;
      end
      @(negedge clk);
      if (injected) begin
        regWrEn = 1'b0; regAddr = STA; regRdEn = 1'b1; injected = 0;
      end
      #1;
      guard++;
    end
    nExp = 128 * (int'(div) + 1);
    chk("R3 busy cycles", 64'(busyCnt), 64'(nExp));
    chk("R4 mdc high cycles", 64'(hi), 64'(64 * (int'(div) + 1)));
    chk("R4 mdc periods", 64'(rises), 64'd64);
    repeat (6) @(negedge clk);
    #1;
    chk("R9 idle after frame", {62'd0, regRdData[0], mdcOut}, 64'd0);
    regRdEn = 1'b0;
    chk("R5 frame header", 64'(captured[63:18]), 64'(expFrame(doWr, phy, rn, dat) >> 18));
    if (doWr) begin
      chk("R6 turnaround and data", 64'(captured[17:0]), 64'({2'b10, dat}));
      rdReg(RDT, got);
      chk("R11 read data kept", 64'(got), 64'(prevRd));
    end else begin
      chk("R7 no drive in read phase", 64'(conflict), 64'd0);
      rdReg(RDT, got);
      chk("R7 read result", 64'(got), 64'(dat));
    end
    wrReg(CMD, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 mdc/oe after reset", {62'd0, mdcOut, mdioOe}, 64'd0);
    rstN = 1'b1;
    rdReg(STA, v); chk("R1 busy after reset", 64'(v), 64'd0);
    rdReg(ADR, v); chk("R1 address after reset", 64'(v), 64'd0);
    rdReg(WDT, v); chk("R1 write data after reset", 64'(v), 64'd0);
    rdReg(RDT, v); chk("R1 read data after reset", 64'(v), 64'd0);
    rdReg(CFG, v); chk("R1 divider after reset", 64'(v), 64'h34);

    wrReg(ADR, 32'hFFFF_FFFF); rdReg(ADR, v); chk("R2 address fields", 64'(v), 64'h1F1F);
    wrReg(CFG, 32'hFFFF_FFFF); rdReg(CFG, v); chk("R2 divider field", 64'(v), 64'h3C);
    wrReg(WDT, 32'hFFFF_FFFF); rdReg(WDT, v); chk("R2 write data field", 64'(v), 64'hFFFF);

    // R10: command with bit 0 clear starts nothing
    wrReg(CMD, 32'hFFFF_FFFE);
    regAddr = STA; regRdEn = 1'b1;
    repeat (20) begin
      @(negedge clk); #1;
      chk("R10 no start", {62'd0, regRdData[0], mdcOut}, 64'd0);
    end
    regRdEn = 1'b0;

    // Write pending from the register test above: first frame is a write (R8)
    runTxn(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 4'd0, -1);
    // Directed: read at the normal divider 0xD
    phyData = 16'hA5C3;
    runTxn(1'b0, 5'h01, 5'h02, 16'hA5C3, 4'hD, -1);
    // R8: write then start again without new write data -> read
    runTxn(1'b1, 5'h05, 5'h10, 16'h1234, 4'd1, -1);
    runTxn(1'b0, 5'h05, 5'h10, 16'h8001, 4'd1, -1);
    chk("R8 opcode is read", 64'(captured[29:28]), 64'd2);
    // R9: start in mid frame, and start on the completing edge
    runTxn(1'b1, 5'h0A, 5'h15, 16'h0F0F, 4'd1, 40);
    runTxn(1'b0, 5'h0A, 5'h15, 16'hF00D, 4'd1, 100);
    runTxn(1'b0, 5'h13, 5'h07, 16'h5A5A, 4'd0, 128);
    runTxn(1'b1, 5'h00, 5'h00, 16'h0000, 4'd0, 128);

    for (int i = 0; i < 16; i++) begin
      bit wr;
      logic [4:0] p, r;
      logic [15:0] d;
      logic [3:0] dv;
      wr = 1'($urandom() % 2);
      p  = 5'($urandom());
      r  = 5'($urandom());
      d  = 16'($urandom());
      dv = 4'($urandom() % 3);
      runTxn(wr, p, r, d, dv, -1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule